// File: doc/BRIEF.md
# Operand Effective Address Generator

This block forms the 16-bit operand address for the memory-operand modes of a small 8-bit processor. A request carries a 3-bit mode code and a 2-bit instruction-kind code. The block then collects however many address or offset bytes that mode needs from a byte-valid instruction stream. When the last byte arrives, it adds the offset to the right base and presents the result with a valid flag.

The base is one of three values: zero (absolute addressing), the 16-bit index pair, or the stack pointer. For the two post-increment modes, the block also watches an operand-fetched strobe. It returns the index pair plus one through a one-cycle write-back strobe.

Some mode and instruction-kind pairings are illegal. For these, the block raises an error flag instead of producing an address. Opcode decoding, the memory and the register file itself sit outside the block.

Top module: `ea_gen`

## Requirements
- R1: A synchronous active-high reset leaves ea_vld_o, err_o and idx_wr_o low and the byte collector idle.
- R2: Mode code 0 (absolute) takes two stream bytes, high byte first, and outputs them as the address {first, second}.
- R3: Mode code 1 (plain index) outputs the index pair as the address on the edge that samples the request.
- R4: Mode code 3 (index plus byte) takes one byte, zero-extends it and adds it to the index pair modulo 2^16.
- R5: Mode code 5 (index plus word) takes two bytes, high byte first, and adds that word to the index pair modulo 2^16.
- R6: Mode code 6 (stack plus byte) takes one byte, zero-extends it and adds it to the stack pointer modulo 2^16.
- R7: Mode code 2 (index, post-increment) addresses the index pair, and mode code 4 (index plus byte, post-increment) addresses index pair plus byte. For both, the edge after fetched_i is sampled high raises idx_wr_o for exactly one cycle, with idx_new_o equal to the captured index pair plus one modulo 2^16 (0xFFFF gives 0x0000).
- R8: Kind codes are 0 other, 1 move, 2 compare-branch. Mode 2 is legal only with kinds 1 and 2, mode 4 only with kind 2, and mode code 7 never. An illegal request sets err_o and keeps ea_vld_o low until the next request. It consumes no bytes and never causes a write-back.
- R9: ea_o and ea_vld_o hold until the next request. fetched_i causes no write-back in a mode without post-increment, nor a second write-back within one request.
- R10: Cycles with byte_vld_i low are waited out, and bytes offered while no collection is pending have no effect on the outputs.
- R11: A new request abandons any collection in progress and clears ea_vld_o and err_o on the edge that samples it, unless the new mode needs no bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 1 | Start an address computation |
| mode_i | input | 3 | Addressing mode code, sampled with req_i |
| kind_i | input | 2 | Instruction kind code, sampled with req_i |
| byte_vld_i | input | 1 | Instruction byte present |
| byte_i | input | 8 | Instruction byte |
| idx_i | input | 16 | Current index pair |
| sp_i | input | 16 | Current stack pointer |
| fetched_i | input | 1 | Operand has been fetched |
| ea_o | output | 16 | Effective address |
| ea_vld_o | output | 1 | Effective address valid |
| err_o | output | 1 | Illegal mode and kind pairing |
| idx_wr_o | output | 1 | Index pair write-back strobe |
| idx_new_o | output | 16 | Incremented index pair |

## Verification
Modes without offset bytes give a valid address one edge after the request. Byte modes give it one edge after the last byte is accepted, however many idle stream cycles came between the bytes. The bench drives every input at the falling edge and compares at the following falling edge, so each comparison falls exactly one register stage after the stimulus edge. The write-back is checked one edge after the fetched strobe and again one edge later, where it must have dropped. Error, hold and ignored-byte cases are compared at the same points against a reference computed by bench functions from the mode, the offsets and the sampled base.

// File: rtl/ea_pkg.sv
package ea_pkg;

   typedef enum logic [2:0] {
      AM_ABS    = 3'd0,
      AM_IDX    = 3'd1,
      AM_IDXP   = 3'd2,
      AM_IDX8   = 3'd3,
      AM_IDX8P  = 3'd4,
      AM_IDX16  = 3'd5,
      AM_STK8   = 3'd6,
      AM_RSVD   = 3'd7
   } amode_e;

   typedef enum logic [1:0] {
      IK_OTHER = 2'd0,
      IK_MOVE  = 2'd1,
      IK_CBR   = 2'd2,
      IK_SPARE = 2'd3
   } ikind_e;

   typedef enum logic [1:0] {
      BS_ZERO  = 2'd0,
      BS_INDEX = 2'd1,
      BS_STACK = 2'd2
   } base_e;

   typedef struct packed {
      logic [1:0] nbytes;
      base_e      base;
      logic       postinc;
   } adec_s;

   function automatic adec_s mode_decode(amode_e m);
      adec_s d;
      d = '{nbytes: 2'd0, base: BS_INDEX, postinc: 1'b0};
      case (m)
         AM_ABS:   begin d.nbytes = 2'd2; d.base = BS_ZERO;  end
         AM_IDX:   begin d.nbytes = 2'd0;                    end
         AM_IDXP:  begin d.nbytes = 2'd0; d.postinc = 1'b1;  end
         AM_IDX8:  begin d.nbytes = 2'd1;                    end
         AM_IDX8P: begin d.nbytes = 2'd1; d.postinc = 1'b1;  end
         AM_IDX16: begin d.nbytes = 2'd2;                    end
         AM_STK8:  begin d.nbytes = 2'd1; d.base = BS_STACK; end
         default:  begin d.nbytes = 2'd0; d.base = BS_ZERO;  end
      endcase
      return d;
   endfunction

   function automatic logic pairing_ok(amode_e m, ikind_e k);
      case (m)
         AM_IDXP:  return (k == IK_MOVE) || (k == IK_CBR);
         AM_IDX8P: return (k == IK_CBR);
         AM_RSVD:  return 1'b0;
         default:  return 1'b1;
      endcase
   endfunction

endpackage

// File: rtl/ea_adder.sv
module ea_adder #(
   parameter int AW     = 16,
   parameter bit SPLIT  = 1'b0
) (
   input  logic [AW-1:0] a_i,
   input  logic [AW-1:0] b_i,
   output logic [AW-1:0] sum_o
);
   localparam int LO = AW / 2;
   localparam int HI = AW - LO;

   if (AW < 2) begin : g_bad_width
      $error("ea_adder: AW must be at least 2");
   end

   if (SPLIT) begin : g_carry_select
      logic [LO:0]   lo_sum;
      logic [HI-1:0] hi_c0;
      logic [HI-1:0] hi_c1;
      always_comb begin
         lo_sum = {1'b0, a_i[LO-1:0]} + {1'b0, b_i[LO-1:0]};
         hi_c0  = a_i[AW-1:LO] + b_i[AW-1:LO];
         hi_c1  = a_i[AW-1:LO] + b_i[AW-1:LO] + HI'(1);
         sum_o  = {lo_sum[LO] ? hi_c1 : hi_c0, lo_sum[LO-1:0]};
      end
   end else begin : g_ripple
      assign sum_o = a_i + b_i;
   end

endmodule

// File: rtl/ea_byte_collect.sv
module ea_byte_collect #(
   parameter int DW = 8,
   parameter int AW = 16,
   parameter int CW = 2
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          start_i,
   input  logic          abort_i,
   input  logic [CW-1:0] need_i,
   input  logic          byte_vld_i,
   input  logic [DW-1:0] byte_i,
   output logic          done_o,
   output logic [AW-1:0] opnd_o
);
   localparam int MAXB = AW / DW;

   if ((AW % DW) != 0 || MAXB >= (1 << CW)) begin : g_bad_cfg
      $error("ea_byte_collect: AW must be a multiple of DW and AW/DW must fit in CW bits");
   end

   logic          busy_q;
   logic [CW-1:0] left_q;
   logic [AW-1:0] acc_q;
   logic          take;
   logic [AW-1:0] acc_next;

   always_comb begin
      take     = busy_q && byte_vld_i && !start_i && !abort_i;
      acc_next = {acc_q[AW-DW-1:0], byte_i};
      done_o   = (start_i && (need_i == '0)) || (take && (left_q == CW'(1)));
      opnd_o   = start_i ? '0 : acc_next;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         busy_q <= 1'b0;
         left_q <= '0;
         acc_q  <= '0;
      end else if (start_i) begin
         busy_q <= (need_i != '0);
         left_q <= need_i;
         acc_q  <= '0;
      end else if (abort_i) begin
         busy_q <= 1'b0;
         left_q <= '0;
      end else if (take) begin
         acc_q  <= acc_next;
         left_q <= left_q - CW'(1);
         if (left_q == CW'(1)) busy_q <= 1'b0;
      end
   end

   AST_BUSY_COUNT: assert property (@(posedge clk) disable iff (rst)
      busy_q |-> (left_q != '0) && (left_q <= CW'(MAXB)));  // R10

   AST_IDLE_NO_DONE: assert property (@(posedge clk) disable iff (rst)
      (!busy_q && !start_i) |-> !done_o);  // R10

endmodule

// File: rtl/ea_postinc.sv
module ea_postinc #(
   parameter int AW = 16
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          arm_i,
   input  logic [AW-1:0] base_i,
   input  logic          clear_i,
   input  logic          fetched_i,
   output logic          wr_o,
   output logic [AW-1:0] new_o
);
   logic          pend_q;
   logic [AW-1:0] base_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         pend_q <= 1'b0;
         base_q <= '0;
         wr_o   <= 1'b0;
         new_o  <= '0;
      end else begin
         wr_o <= 1'b0;
         if (arm_i) begin
            pend_q <= 1'b1;
            base_q <= base_i;
         end else if (clear_i) begin
            pend_q <= 1'b0;
         end else if (pend_q && fetched_i) begin
            pend_q <= 1'b0;
            wr_o   <= 1'b1;
            new_o  <= base_q + AW'(1);
         end
      end
   end

   AST_WB_SINGLE: assert property (@(posedge clk) disable iff (rst)
      wr_o |=> !wr_o);  // R7

   AST_WB_CAUSE: assert property (@(posedge clk) disable iff (rst)
      wr_o |-> $past(fetched_i));  // R7

   AST_WB_ONCE: assert property (@(posedge clk) disable iff (rst)
      (wr_o && !arm_i) |=> !pend_q);  // R9

endmodule

// File: rtl/ea_gen.sv
module ea_gen #(
   parameter int AW        = 16,
   parameter int DW        = 8,
   parameter bit SPLIT_ADD = 1'b1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          req_i,
   input  logic [2:0]    mode_i,
   input  logic [1:0]    kind_i,
   input  logic          byte_vld_i,
   input  logic [DW-1:0] byte_i,
   input  logic [AW-1:0] idx_i,
   input  logic [AW-1:0] sp_i,
   input  logic          fetched_i,
   output logic [AW-1:0] ea_o,
   output logic          ea_vld_o,
   output logic          err_o,
   output logic          idx_wr_o,
   output logic [AW-1:0] idx_new_o
);
   import ea_pkg::*;

   localparam int CW = 2;

   if (AW != 2 * DW) begin : g_bad_width
      $error("ea_gen: address must be exactly two stream bytes wide");
   end

   amode_e          mode_q;
   amode_e          act_mode;
   adec_s           dec;
   logic            legal;
   logic            start;
   logic            abort;
   logic            done;
   logic [AW-1:0]   opnd;
   logic [AW-1:0]   base;
   logic [AW-1:0]   sum;

   always_comb begin
      act_mode = req_i ? amode_e'(mode_i) : mode_q;
      dec      = mode_decode(act_mode);
      legal    = pairing_ok(amode_e'(mode_i), ikind_e'(kind_i));
      start    = req_i && legal;
      abort    = req_i && !legal;
      case (dec.base)
         BS_INDEX: base = idx_i;
         BS_STACK: base = sp_i;
         default:  base = '0;
      endcase
   end

   ea_byte_collect #(.DW(DW), .AW(AW), .CW(CW)) u_collect (
      .clk        (clk),
      .rst        (rst),
      .start_i    (start),
      .abort_i    (abort),
      .need_i     (dec.nbytes),
      .byte_vld_i (byte_vld_i),
      .byte_i     (byte_i),
      .done_o     (done),
      .opnd_o     (opnd)
   );

   ea_adder #(.AW(AW), .SPLIT(SPLIT_ADD)) u_add (
      .a_i   (base),
      .b_i   (opnd),
      .sum_o (sum)
   );

   ea_postinc #(.AW(AW)) u_postinc (
      .clk       (clk),
      .rst       (rst),
      .arm_i     (done && dec.postinc),
      .base_i    (idx_i),
      .clear_i   (req_i),
      .fetched_i (fetched_i),
      .wr_o      (idx_wr_o),
      .new_o     (idx_new_o)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         mode_q   <= AM_ABS;
         ea_o     <= '0;
         ea_vld_o <= 1'b0;
         err_o    <= 1'b0;
      end else begin
         if (req_i) begin
            mode_q   <= amode_e'(mode_i);
            ea_vld_o <= 1'b0;
            err_o    <= !legal;
         end
         if (done) begin
            ea_o     <= sum;
            ea_vld_o <= 1'b1;
         end
      end
   end

   AST_ERR_NO_ADDR: assert property (@(posedge clk) disable iff (rst)
      err_o |-> !ea_vld_o);  // R8

   AST_ERR_NO_WB: assert property (@(posedge clk) disable iff (rst)
      err_o |-> !idx_wr_o);  // R8

   AST_ILLEGAL_FLAG: assert property (@(posedge clk) disable iff (rst)
      (req_i && mode_i == 3'd7) |=> (err_o && !ea_vld_o));  // R8

   AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
      (ea_vld_o && !req_i) |=> (ea_vld_o && $stable(ea_o)));  // R9

   AST_WB_WITH_ADDR: assert property (@(posedge clk) disable iff (rst)
      idx_wr_o |-> ea_vld_o);  // R7

   AST_REQ_NO_WB: assert property (@(posedge clk) disable iff (rst)
      req_i |=> !idx_wr_o);  // R11

endmodule

// File: tb/ea_gen_bench.sv
module ea_gen_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst;
   logic        req;
   logic [2:0]  mode;
   logic [1:0]  kind;
   logic        bvld;
   logic [7:0]  bdat;
   logic [15:0] idx;
   logic [15:0] sp;
   logic        fetched;
   logic [15:0] ea;
   logic        ea_vld;
   logic        err;
   logic        idx_wr;
   logic [15:0] idx_new;

   int n_chk = 0;
   int n_err = 0;
   bit done_flag = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ea_gen u_ea_gen (
      .clk(clk), .rst(rst), .req_i(req), .mode_i(mode), .kind_i(kind),
      .byte_vld_i(bvld), .byte_i(bdat), .idx_i(idx), .sp_i(sp),
      .fetched_i(fetched), .ea_o(ea), .ea_vld_o(ea_vld), .err_o(err),
      .idx_wr_o(idx_wr), .idx_new_o(idx_new)
   );

   task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   function automatic int nbytes(int m);
      case (m)
         0, 5:    return 2;
         3, 4, 6: return 1;
         default: return 0;
      endcase
   endfunction

   function automatic logic [15:0] ref_ea(int m, logic [15:0] ix, logic [15:0] s,
                                          logic [7:0] b0, logic [7:0] b1);
      case (m)
         0:       return {b0, b1};
         1, 2:    return ix;
         3, 4:    return ix + {8'h00, b0};
         5:       return ix + {b0, b1};
         6:       return s + {8'h00, b0};
         default: return 16'h0000;
      endcase
   endfunction

   function automatic bit ref_legal(int m, int k);
      if (m == 2) return (k == 1) || (k == 2);
      if (m == 4) return (k == 2);
      if (m == 7) return 0;
      return 1;
   endfunction

   function automatic string tag(int m);
      case (m)
         0:       return "R2";
         1:       return "R3";
         3:       return "R4";
         5:       return "R5";
         6:       return "R6";
         2, 4:    return "R7";
         default: return "R8";
      endcase
   endfunction

   // request, feed bytes with gaps, check result one edge after the last byte
   task automatic run(input int m, input int k, input logic [15:0] ix, input logic [15:0] s,
                      input logic [7:0] b0, input logic [7:0] b1, input int gap);
      @(negedge clk);
      mode = 3'(m); kind = 2'(k); req = 1'b1; idx = ix; sp = s;
      @(negedge clk);
      req = 1'b0;
      if (ref_legal(m, k)) begin
         for (int i = 0; i < nbytes(m); i++) begin
            repeat (gap) @(negedge clk);
            bdat = (i == 0) ? b0 : b1; bvld = 1'b1;
            @(negedge clk);
            bvld = 1'b0;
         end
         check({tag(m), " valid"}, ea_vld, 1);
         check({tag(m), " address"}, ea, ref_ea(m, ix, s, b0, b1));
         check("R8 no error on legal pairing", err, 0);
      end else begin
         check("R8 error flag", err, 1);
         check("R8 no address", ea_vld, 0);
      end
   endtask

   task automatic fetch(input bit exp_wr, input logic [15:0] exp_new, input string rq);
      fetched = 1'b1;
      @(negedge clk);
      fetched = 1'b0;
      check({rq, " write-back strobe"}, idx_wr, exp_wr);
      if (exp_wr) check({rq, " incremented index"}, idx_new, exp_new);
      @(negedge clk);
      check({rq, " strobe is one cycle"}, idx_wr, 0);
   endtask

   task automatic finish_up();
      if (!done_flag) begin
         done_flag = 1;
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_up();
   end

   initial begin
      logic [15:0] hold_ea;
      void'($urandom(32'd20240611));
      rst = 1'b1; req = 0; mode = 0; kind = 0; bvld = 0; bdat = 0;
      idx = 0; sp = 0; fetched = 0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      check("R1 valid after reset", ea_vld, 0);
      check("R1 error after reset", err, 0);
      check("R1 strobe after reset", idx_wr, 0);

      // R10 bytes with no pending collection are ignored
      bdat = 8'hAA; bvld = 1'b1;
      repeat (2) @(negedge clk);
      bvld = 1'b0;
      check("R10 stray bytes give no address", ea_vld, 0);

      run(0, 0, 16'h0000, 16'h0000, 8'h12, 8'h34, 2);       // R2 with R10 gaps
      run(1, 0, 16'hBEEF, 16'h0000, 8'h00, 8'h00, 0);       // R3
      fetch(0, 16'h0, "R9 no post-increment");
      run(3, 0, 16'hFFF0, 16'h0000, 8'h20, 8'h00, 1);       // R4 wrap
      run(5, 3, 16'h8000, 16'h0000, 8'h90, 8'h01, 0);       // R5 wrap
      run(6, 0, 16'h0000, 16'h00FF, 8'hFF, 8'h00, 3);       // R6
      run(2, 1, 16'hFFFF, 16'h0000, 8'h00, 8'h00, 0);       // R7
      fetch(1, 16'h0000, "R7 wrap");
      fetch(0, 16'h0, "R9 second fetch");
      run(4, 2, 16'h1234, 16'h0000, 8'h10, 8'h00, 0);       // R7
      fetch(1, 16'h1235, "R7 offset form");

      // R9 hold under stray bytes and idle cycles
      hold_ea = ea;
      bdat = 8'h55; bvld = 1'b1;
      repeat (3) @(negedge clk);
      bvld = 1'b0;
      check("R9 address held", ea, hold_ea);
      check("R9 valid held", ea_vld, 1);

      run(2, 0, 16'h1000, 16'h0000, 8'h00, 8'h00, 0);       // R8 illegal
      fetch(0, 16'h0, "R8 no write-back on error");
      run(4, 1, 16'h1000, 16'h0000, 8'h00, 8'h00, 0);       // R8 illegal
      run(7, 0, 16'h1000, 16'h0000, 8'h00, 8'h00, 0);       // R8 reserved
      bdat = 8'h77; bvld = 1'b1;
      @(negedge clk);
      bvld = 1'b0;
      check("R8 bytes after error ignored", ea_vld, 0);

      // R11 restart mid-collection
      @(negedge clk);
      mode = 3'd0; kind = 2'd0; req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      check("R11 request clears valid", ea_vld, 0);
      check("R11 request clears error", err, 0);
      bdat = 8'hC3; bvld = 1'b1;
      @(negedge clk);
      bvld = 1'b0;
      run(1, 0, 16'h4321, 16'h0000, 8'h00, 8'h00, 0);
      check("R11 restart address", ea, 16'h4321);

      // random mix
      for (int it = 0; it < 80; it++) begin
         int m, k, g;
         logic [15:0] ix, s;
         logic [7:0]  b0, b1;
         m  = $urandom % 7;
         k  = $urandom % 4;
         if (m == 2) k = 1 + ($urandom % 2);
         if (m == 4) k = 2;
         g  = $urandom % 3;
         ix = 16'($urandom); s = 16'($urandom);
         b0 = 8'($urandom);  b1 = 8'($urandom);
         run(m, k, ix, s, b0, b1, g);
         if (m == 2 || m == 4) fetch(1, ix + 16'h0001, "R7 random");
         else if ($urandom % 2 == 1) fetch(0, 16'h0, "R9 random");
      end

      repeat (2) @(negedge clk);
      finish_up();
   end

endmodule